// File: doc/BRIEF.md
# Remote error indication accumulator

This block turns the remote error indication byte of each received SONET/SDH frame (the M1 byte) into two running error totals. Each time a frame is marked valid, the byte is read as a count of remote BIP errors. A count that is too large for the selected line rate is treated as zero. The block then adds the count to a BIP error counter. From the same count it works out a number of remote errored blocks and adds that to a second counter.

A block can be defined in two ways. It can be the whole frame, or it can be one STM-1 equivalent within the frame. At the highest rate this gives either 1 block or 16 blocks per frame. Both counters saturate at all-ones instead of wrapping. A processor reads the totals through a snapshot request. The request copies both live counters into holding registers, which drive the outputs, and restarts the live counters in the same cycle. Errors that arrive in the snapshot cycle are counted in the new interval, so none are lost.

Top module: `rei_accum`

## Requirements
- R1: After reset, both outputs read zero, and a snapshot taken before any frame also returns zero for both counts.
- R2: On a cycle with `frame_vld` high, a legal `m1_byte` value is added to the BIP count. The largest legal value depends on `rate_sel`: 0 (STS-1) allows 8, 1 (STS-3) allows 24, 2 (STS-12) allows 96, and 3 (STS-48) allows 255.
- R3: An `m1_byte` value above the largest legal value for the current rate counts as zero errors, so it adds nothing to either counter.
- R4: With `blk_per_stm1` low (whole-frame blocks), the block count rises by one for each valid frame whose decoded error count is nonzero.
- R5: With `blk_per_stm1` high, the block count rises by the smaller of the decoded error count and the number of STM-1 equivalents at the rate. That number is 1 for `rate_sel` 0 and 1, 4 for `rate_sel` 2, and 16 for `rate_sel` 3.
- R6: The BIP count saturates at all-ones and never wraps.
- R7: The block count saturates at all-ones and never wraps.
- R8: When `snap_req` is high on a clock edge, both outputs take the live totals as they stood before that edge. The live counters restart from that cycle's increment, which is zero when no frame is valid in that cycle.
- R9: On cycles with `frame_vld` low, `m1_byte` is ignored and the counters do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe: `m1_byte` holds this frame's value |
| m1_byte | input | 8 | Received remote error indication byte |
| blk_per_stm1 | input | 1 | 0: a block is one whole frame; 1: a block is one STM-1 equivalent |
| rate_sel | input | 2 | Line rate: 0 STS-1, 1 STS-3, 2 STS-12, 3 STS-48 |
| snap_req | input | 1 | Copy live counts to the outputs and restart the live counts |
| bip_cnt | output | BIP_W (21) | Snapshot of the remote BIP error count |
| blk_cnt | output | BLK_W (17) | Snapshot of the remote errored block count |

## Verification
The bench builds the block with BIP_W set to 12 and BLK_W set to 7. At these widths the counters saturate after about twenty full-rate frames carrying 255 errors, so the clamping in R6 and R7 is exercised in a short run. The width parameters feed only the adders and the clamp, so the legality limits and the per-rate block counts at the smaller widths match those at the default widths of 21 and 17.

// File: rtl/rei_pkg.sv
// Shared types and per-rate constants for the remote error indication accumulator.
// Assumes the line rate code is stable while a frame strobe is presented.
package rei_pkg;

    localparam int M1_W      = 8;
    localparam int BLK_INC_W = 5;

    typedef enum logic [1:0] {
        RATE_STS1  = 2'd0,
        RATE_STS3  = 2'd1,
        RATE_STS12 = 2'd2,
        RATE_STS48 = 2'd3
    } rate_e;

    // Largest remote error count the byte may legally carry at a rate.
    function automatic logic [M1_W-1:0] max_legal(input rate_e r);
        case (r)
            RATE_STS1:  max_legal = 8'd8;
            RATE_STS3:  max_legal = 8'd24;
            RATE_STS12: max_legal = 8'd96;
            default:    max_legal = 8'd255;
        endcase
    endfunction

    // Number of STM-1 equivalents carried in one frame at a rate.
    function automatic logic [BLK_INC_W-1:0] stm1_count(input rate_e r);
        case (r)
            RATE_STS1:  stm1_count = 5'd1;
            RATE_STS3:  stm1_count = 5'd1;
            RATE_STS12: stm1_count = 5'd4;
            default:    stm1_count = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/rei_decode.sv
// Decodes one received M1 byte into a BIP error increment and a block error increment.
// Purely combinational; both increments are zero when no frame is valid.
// Assumes rate_sel and blk_per_stm1 are quasi-static configuration.
module rei_decode
    import rei_pkg::*;
(
    input  logic                 frame_vld,
    input  logic [M1_W-1:0]      m1_byte,
    input  logic                 blk_per_stm1,
    input  logic [1:0]           rate_sel,
    output logic [M1_W-1:0]      bip_inc,
    output logic [BLK_INC_W-1:0] blk_inc
);

    rate_e                 rate;
    logic [M1_W-1:0]       err;
    logic [BLK_INC_W-1:0]  cap;

    // Legality check: counts beyond the rate's limit are taken as no errors.
    always_comb begin
        rate = rate_e'(rate_sel);
        err  = (frame_vld && (m1_byte <= max_legal(rate))) ? m1_byte : '0;
        cap  = stm1_count(rate);
    end

    // Block evaluation under the selected block definition.
    always_comb begin
        bip_inc = err;
        if (!blk_per_stm1) begin
            blk_inc = (err != '0) ? BLK_INC_W'(1) : '0;
        end else if (err >= M1_W'(cap)) begin
            blk_inc = cap;
        end else begin
            blk_inc = err[BLK_INC_W-1:0];
        end
    end

endmodule

// File: rtl/rei_sat_acc.sv
// Saturating accumulator with a snapshot holding register.
// On clr the holding register takes the live value, and the live value restarts at inc.
// Assumes W >= INC_W.
module rei_sat_acc #(
    parameter int W     = 21,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             clr,
    output logic [W-1:0]     live,
    output logic [W-1:0]     hold
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic [W-1:0]     nxt;

    // Next live value: restart or add, clamped to all-ones on carry out.
    always_comb begin
        base = clr ? '0 : {1'b0, live};
        sum  = base + {{(SUM_W-INC_W){1'b0}}, inc};
        nxt  = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end

    // Live and holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
            hold <= '0;
        end else begin
            live <= nxt;
            if (clr) begin
                hold <= live;
            end
        end
    end

endmodule

// File: rtl/rei_accum.sv
// Remote error indication accumulator: decodes M1 once per frame and keeps
// saturating BIP and block error totals, read out through a snapshot.
// Assumes frame_vld is a single-cycle strobe per received frame.
module rei_accum
    import rei_pkg::*;
#(
    parameter int BIP_W = 21,
    parameter int BLK_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_vld,
    input  logic [7:0]       m1_byte,
    input  logic             blk_per_stm1,
    input  logic [1:0]       rate_sel,
    input  logic             snap_req,
    output logic [BIP_W-1:0] bip_cnt,
    output logic [BLK_W-1:0] blk_cnt
);

    logic [M1_W-1:0]      bip_inc;
    logic [BLK_INC_W-1:0] blk_inc;
    logic [BIP_W-1:0]     live_bip;
    logic [BLK_W-1:0]     live_blk;

    rei_decode u_decode (
        .frame_vld    (frame_vld),
        .m1_byte      (m1_byte),
        .blk_per_stm1 (blk_per_stm1),
        .rate_sel     (rate_sel),
        .bip_inc      (bip_inc),
        .blk_inc      (blk_inc)
    );

    rei_sat_acc #(.W(BIP_W), .INC_W(M1_W)) u_bip_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (bip_inc),
        .clr   (snap_req),
        .live  (live_bip),
        .hold  (bip_cnt)
    );

    rei_sat_acc #(.W(BLK_W), .INC_W(BLK_INC_W)) u_blk_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (blk_inc),
        .clr   (snap_req),
        .live  (live_blk),
        .hold  (blk_cnt)
    );

endmodule

// File: rtl/rei_accum_chk.sv
// Property checker for rei_accum, attached through bind.
// Watches the decode increments, the live counters and the snapshot outputs.
module rei_accum_chk #(
    parameter int BIP_W = 21,
    parameter int BLK_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_vld,
    input logic             snap_req,
    input logic [7:0]       bip_inc,
    input logic [4:0]       blk_inc,
    input logic [BIP_W-1:0] live_bip,
    input logic [BLK_W-1:0] live_blk,
    input logic [BIP_W-1:0] bip_cnt,
    input logic [BLK_W-1:0] blk_cnt
);

    // R5: a frame never yields more blocks than errors, nor more than 16.
    always_comb begin
        if (rst_n) begin
            a_r5_blk_bound: assert (blk_inc <= 5'd16 && {3'b0, blk_inc} <= bip_inc);
        end
    end

    // R8: a snapshot moves the pre-edge live totals to the outputs.
    a_r8_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (bip_cnt == $past(live_bip)) && (blk_cnt == $past(live_blk)));

    // R8: outputs hold between snapshots.
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(bip_cnt) && $stable(blk_cnt));

    // R6: the BIP total never falls without a snapshot.
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> live_bip >= $past(live_bip));

    // R7: the block total never falls without a snapshot.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> live_blk >= $past(live_blk));

    // R9: with no frame and no snapshot, the live totals are unchanged.
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_vld && !snap_req) |=> $stable(live_bip) && $stable(live_blk));

endmodule

bind rei_accum rei_accum_chk #(.BIP_W(BIP_W), .BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_vld (frame_vld),
    .snap_req  (snap_req),
    .bip_inc   (bip_inc),
    .blk_inc   (blk_inc),
    .live_bip  (live_bip),
    .live_blk  (live_blk),
    .bip_cnt   (bip_cnt),
    .blk_cnt   (blk_cnt)
);

// File: tb/rei_accum_tb.sv
// Scoreboard bench: the driver models expected totals and queues them at each
// snapshot; the monitor compares outputs after every snapshot edge.
module rei_accum_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BIP_W      = 12;
    localparam int BLK_W      = 7;
    localparam int BIP_MAX    = (1 << BIP_W) - 1;
    localparam int BLK_MAX    = (1 << BLK_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_vld = 1'b0;
    logic [7:0]       m1_byte = '0;
    logic             blk_per_stm1 = 1'b0;
    logic [1:0]       rate_sel = 2'd3;
    logic             snap_req = 1'b0;
    logic [BIP_W-1:0] bip_cnt;
    logic [BLK_W-1:0] blk_cnt;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    int    m_bip = 0;
    int    m_blk = 0;
    int    q_bip[$];
    int    q_blk[$];
    string q_tb[$];
    string q_tk[$];

    rei_accum #(.BIP_W(BIP_W), .BLK_W(BLK_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_vld    (frame_vld),
        .m1_byte      (m1_byte),
        .blk_per_stm1 (blk_per_stm1),
        .rate_sel     (rate_sel),
        .snap_req     (snap_req),
        .bip_cnt      (bip_cnt),
        .blk_cnt      (blk_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lim(input int r);
        case (r)
            0: lim = 8;
            1: lim = 24;
            2: lim = 96;
            default: lim = 255;
        endcase
    endfunction

    function automatic int nstm(input int r);
        case (r)
            2: nstm = 4;
            3: nstm = 16;
            default: nstm = 1;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, model update, and queueing on snapshot.
    task automatic step(input bit fv, input int m1, input bit sn,
                        input string tb, input string tk);
        int e;
        int b;
        frame_vld = fv;
        m1_byte   = 8'(m1);
        snap_req  = sn;
        e = (fv && m1 <= lim(int'(rate_sel))) ? m1 : 0;
        if (!blk_per_stm1) b = (e != 0) ? 1 : 0;
        else b = (e < nstm(int'(rate_sel))) ? e : nstm(int'(rate_sel));
        if (sn) begin
            q_bip.push_back(m_bip);
            q_blk.push_back(m_blk);
            q_tb.push_back(tb);
            q_tk.push_back(tk);
            m_bip = 0;
            m_blk = 0;
        end
        m_bip = (m_bip + e > BIP_MAX) ? BIP_MAX : m_bip + e;
        m_blk = (m_blk + b > BLK_MAX) ? BLK_MAX : m_blk + b;
        @(negedge clk);
        frame_vld = 1'b0;
        snap_req  = 1'b0;
    endtask

    task automatic frame(input int m1);
        step(1'b1, m1, 1'b0, "", "");
    endtask

    task automatic snap(input string tb, input string tk);
        step(1'b0, 0, 1'b1, tb, tk);
    endtask

    // Monitor: after each snapshot edge, compare the outputs with the queued totals.
    always @(posedge clk) begin
        if (rst_n && snap_req) begin
            @(negedge clk);
            if (q_bip.size() == 0) begin
                check("R8", "queue empty", 1, 0);
            end else begin
                check(q_tb[0], "bip_cnt", int'(bip_cnt), q_bip[0]);
                check(q_tk[0], "blk_cnt", int'(blk_cnt), q_blk[0]);
                void'(q_bip.pop_front());
                void'(q_blk.pop_front());
                void'(q_tb.pop_front());
                void'(q_tk.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "bip_cnt after reset", int'(bip_cnt), 0);
        check("R1", "blk_cnt after reset", int'(blk_cnt), 0);
        snap("R1", "R1");

        // R2 R4: full rate, whole-frame blocks.
        rate_sel = 2'd3; blk_per_stm1 = 1'b0;
        frame(5); frame(0); frame(200);
        snap("R2", "R4");

        // R3: limits at each lower rate; one above the limit counts as zero.
        rate_sel = 2'd0; frame(8); frame(9); frame(200);
        rate_sel = 2'd1; frame(24); frame(25);
        rate_sel = 2'd2; frame(96); frame(97);
        snap("R3", "R3");

        // R5: per-STM-1 blocks at full rate, then at the lower rates.
        rate_sel = 2'd3; blk_per_stm1 = 1'b1;
        frame(3); frame(40); frame(0); frame(16);
        snap("R5", "R5");
        rate_sel = 2'd2; frame(10); frame(2);
        rate_sel = 2'd0; frame(5);
        snap("R5", "R5");

        // R9: byte ignored without the frame strobe.
        rate_sel = 2'd3;
        step(1'b0, 50, 1'b0, "", ""); step(1'b0, 255, 1'b0, "", "");
        snap("R9", "R9");

        // R8: frame in the snapshot cycle lands in the next interval.
        blk_per_stm1 = 1'b0;
        frame(7);
        step(1'b1, 9, 1'b1, "R8", "R8");
        snap("R8", "R8");
        snap("R8", "R8");

        // R6 R7: saturation at the bench widths.
        blk_per_stm1 = 1'b1;
        for (int i = 0; i < 20; i++) frame(255);
        snap("R6", "R7");
        frame(4);
        snap("R6", "R7");

        repeat (3) @(negedge clk);
        check("R8", "queue drained", q_bip.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule